// File: doc/BRIEF.md
# Soft-Decision Register-Exchange Viterbi Decoder

This block decodes a stream protected by a rate-1/2 convolutional code with four trellis states and generator taps 1+D+D² and 1+D². Every accepted cycle brings one pair of 3-bit soft channel samples. The block turns the pair into four branch costs and runs one add-compare-select per state to update a set of path metrics. It then moves whole survivor histories between the states, so no trace-back pass is needed.

After a fixed truncation depth the block returns one decoded bit per accepted pair. Three selectable rules choose which history supplies that bit: the oldest bit held by state 0, the oldest bit of the state with the lowest metric, or a majority vote over the oldest bits of all four states. Path metrics are narrow and wrap around, and comparisons are done on their modular difference, so the metrics never have to be rescaled.

Top module: `vit_re_decoder`

## Requirements
- R1: While reset is held and afterwards, until TRUNC_LEN pairs have been accepted, `outValid` stays 0. Reset also clears `outBit` to 0.
- R2: Starting with the TRUNC_LEN-th accepted pair, `outValid` is 1 in the cycle after each accepted pair and 0 in every other cycle.
- R3: Each sample takes a level from 0 to 7, where 0 is the ideal level for a sent 0 and 7 the ideal level for a sent 1. The distance to a 0 is the sample value, and the distance to a 1 is its 3-bit complement. A hypothesis cost is the sum of the two distances.
- R4: The state is {u[i-1], u[i-2]}. State s is reached from predecessors ((s<<1)&3) and ((s<<1)&3)|1 with input bit s[1]. The expected code bits are u^u1^u2 for `symA` and u^u2 for `symB`. The new metric is the smaller of the two candidate sums, and on a tie the even predecessor is kept.
- R5: After reset, state 0 starts with metric 0 and every other state starts with a start-up penalty. No path that comes from that penalty wins against a path that starts in state 0.
- R6: Each state's history is TRUNC_LEN bits long. It is replaced by the winner's history shifted by one, with s[1] appended. On a noiseless channel the n-th decoded bit equals the n-th information bit.
- R7: With `ruleSel` 2'b00 (and also with the spare value 2'b11), the decoded bit is the oldest bit of state 0's history.
- R8: With `ruleSel` 2'b01, the decoded bit is the oldest history bit of the state with the lowest metric. On a tie the lowest state index is used.
- R9: With `ruleSel` 2'b10, the decoded bit is 1 only when more than two of the four oldest history bits are 1. A 2–2 split gives 0.
- R10: Metrics are PM_W bits wide and wrap. Decoding stays exact over runs long enough to wrap them many times.
- R11: A cycle with `inValid` low changes neither the metrics, the histories nor `outBit`, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The sample pair on this cycle is accepted |
| symA | input | SYM_W | Soft sample of the first code bit |
| symB | input | SYM_W | Soft sample of the second code bit |
| ruleSel | input | 2 | Output rule: 00 fixed state, 01 best state, 10 majority, 11 as 00 |
| outValid | output | 1 | Decoded bit valid |
| outBit | output | 1 | Decoded bit |

## Verification
Noiseless encoded streams show that the trellis wiring and the history exchange return the sent bits after the truncation delay. Streams with moderate noise, passed through the best-state rule, exercise real metric competition and the tie rules. Fully random samples force the histories to disagree often, so the majority rule and its 2–2 case give results that differ visibly from the fixed-state rule. A rule change on every pair, random idle gaps that carry junk samples, saturated samples, and a run of thousands of pairs that wraps the metrics many times separate the per-cycle rule selection, the hold behaviour and the modular comparison.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int NUM_STATES = 4;
  localparam int STATE_W    = 2;

  typedef enum logic [1:0] {
    OUT_FIXED    = 2'b00,
    OUT_BEST     = 2'b01,
    OUT_MAJORITY = 2'b10,
    OUT_SPARE    = 2'b11
  } outRule_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // accept the pair on this edge
    logic emit;   // this step produces a valid decoded bit
  } vitCtl_t;
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
  parameter int SYM_W = 3,
  localparam int BM_W = SYM_W + 1
) (
  input  logic [SYM_W-1:0]      symA,
  input  logic [SYM_W-1:0]      symB,
  output logic [3:0][BM_W-1:0]  bmAll   // index {c1,c2}
);
  logic [SYM_W-1:0] invA;
  logic [SYM_W-1:0] invB;
  logic [BM_W-1:0]  zeroA, oneA, zeroB, oneB;

  assign invA  = ~symA;
  assign invB  = ~symB;
  assign zeroA = BM_W'(symA);
  assign oneA  = BM_W'(invA);
  assign zeroB = BM_W'(symB);
  assign oneB  = BM_W'(invB);

  assign bmAll[0] = zeroA + zeroB;
  assign bmAll[1] = zeroA + oneB;
  assign bmAll[2] = oneA  + zeroB;
  assign bmAll[3] = oneA  + oneB;
endmodule

// File: rtl/vit_outsel.sv
module vit_outsel
  import vit_pkg::*;
#(
  parameter int PM_W = 7
) (
  input  logic [1:0]                       ruleSel,
  input  logic [NUM_STATES-1:0][PM_W-1:0]  pmNew,
  input  logic [NUM_STATES-1:0]            oldest,
  output logic                             pickBit
);
  localparam int ONES_W = $clog2(NUM_STATES + 1);

  logic [STATE_W-1:0] bestIdx;
  logic [PM_W-1:0]    gap;
  logic [ONES_W-1:0]  ones;

  // modular minimum search, lowest index wins ties
  always_comb begin
    bestIdx = '0;
    gap     = '0;
    for (int s = 1; s < NUM_STATES; s++) begin
      gap = pmNew[s] - pmNew[bestIdx];
      if (gap[PM_W-1]) bestIdx = STATE_W'(s);
    end
  end

  assign ones = ONES_W'($countones(oldest));

  always_comb begin
    case (outRule_e'(ruleSel))
      OUT_BEST:     pickBit = oldest[bestIdx];
      OUT_MAJORITY: pickBit = (ones > ONES_W'(NUM_STATES / 2));
      default:      pickBit = oldest[0];
    endcase
  end
endmodule

// File: rtl/vit_ctrl.sv
module vit_ctrl
  import vit_pkg::*;
#(
  parameter int TRUNC_LEN = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output vitCtl_t ctl,
  output logic    outValid
);
  localparam int CNT_W = $clog2(TRUNC_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(TRUNC_LEN - 1);

  logic [CNT_W-1:0] fillCnt;
  logic             filled;

  assign filled = (fillCnt >= LAST_FILL);

  always_comb begin
    ctl.step = inValid;
    ctl.emit = inValid && filled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.emit;
      if (inValid && !filled) fillCnt <= fillCnt + 1'b1;
    end
  end

  // independent step tally for the checks below
  int unsigned seenSteps;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenSteps <= 0;
    else if (inValid && seenSteps < TRUNC_LEN) seenSteps <= seenSteps + 1;
  end

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (seenSteps < TRUNC_LEN) |-> !outValid); // R1
  AST_OUT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R2
  AST_OUT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && seenSteps >= TRUNC_LEN - 1) |=> outValid); // R2
endmodule

// File: rtl/vit_datapath.sv
module vit_datapath
  import vit_pkg::*;
#(
  parameter int SYM_W     = 3,
  parameter int PM_W      = 7,
  parameter int TRUNC_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  vitCtl_t          ctl,
  input  logic [SYM_W-1:0] symA,
  input  logic [SYM_W-1:0] symB,
  input  logic [1:0]       ruleSel,
  output logic             outBit
);
  localparam int BM_W = SYM_W + 1;
  localparam logic [PM_W-1:0] PM_START_PENALTY = PM_W'(1) << (PM_W - 2);

  logic [3:0][BM_W-1:0]                   bmAll;
  logic [NUM_STATES-1:0][PM_W-1:0]        pm, pmNext;
  logic [NUM_STATES-1:0][TRUNC_LEN-1:0]   surv, survNext;
  logic [NUM_STATES-1:0]                  dec;
  logic [NUM_STATES-1:0]                  oldest;
  logic                                   pickBit;

  vit_bmu #(.SYM_W(SYM_W)) u_bmu (
    .symA  (symA),
    .symB  (symB),
    .bmAll (bmAll)
  );

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_acs
    localparam int IN_BIT = s >> 1;
    localparam int PRED_A = (s << 1) % NUM_STATES;
    localparam int PRED_B = PRED_A + 1;
    localparam int BM_A   = 2 * (IN_BIT ^ (PRED_A >> 1) ^ (PRED_A & 1)) + (IN_BIT ^ (PRED_A & 1));
    localparam int BM_B   = 2 * (IN_BIT ^ (PRED_B >> 1) ^ (PRED_B & 1)) + (IN_BIT ^ (PRED_B & 1));

    logic [PM_W-1:0] sumA, sumB, diff;

    assign sumA = pm[PRED_A] + PM_W'(bmAll[BM_A]);
    assign sumB = pm[PRED_B] + PM_W'(bmAll[BM_B]);
    assign diff = sumB - sumA;
    assign dec[s] = diff[PM_W-1];   // odd predecessor strictly cheaper
    assign pmNext[s] = dec[s] ? sumB : sumA;
    assign survNext[s] = {(dec[s] ? surv[PRED_B][TRUNC_LEN-2:0] : surv[PRED_A][TRUNC_LEN-2:0]),
                          1'(IN_BIT)};
    assign oldest[s] = survNext[s][TRUNC_LEN-1];

    AST_SURV_EXCHANGE: assert property (@(posedge clk) disable iff (!rstN)
      ctl.step |=> (surv[s][TRUNC_LEN-1:1] == $past(surv[PRED_A][TRUNC_LEN-2:0])) ||
                   (surv[s][TRUNC_LEN-1:1] == $past(surv[PRED_B][TRUNC_LEN-2:0]))); // R6
  end

  vit_outsel #(.PM_W(PM_W)) u_outsel (
    .ruleSel (ruleSel),
    .pmNew   (pmNext),
    .oldest  (oldest),
    .pickBit (pickBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STATES; s++) pm[s] <= (s == 0) ? '0 : PM_START_PENALTY;
      surv   <= '0;
      outBit <= 1'b0;
    end else if (ctl.step) begin
      pm     <= pmNext;
      surv   <= survNext;
      outBit <= pickBit;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> $stable(pm) && $stable(surv) && $stable(outBit)); // R11
  AST_FIXED_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ruleSel == 2'b00) |=> (outBit == surv[0][TRUNC_LEN-1])); // R7
  AST_MAJORITY_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ruleSel == 2'b10) |=>
      (outBit == ($countones({surv[3][TRUNC_LEN-1], surv[2][TRUNC_LEN-1],
                              surv[1][TRUNC_LEN-1], surv[0][TRUNC_LEN-1]}) > 2))); // R9
endmodule

// File: rtl/vit_re_decoder.sv
module vit_re_decoder
  import vit_pkg::*;
#(
  parameter int SYM_W     = 3,
  parameter int PM_W      = 7,
  parameter int TRUNC_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SYM_W-1:0] symA,
  input  logic [SYM_W-1:0] symB,
  input  logic [1:0]       ruleSel,
  output logic             outValid,
  output logic             outBit
);
  vitCtl_t ctl;

  vit_ctrl #(.TRUNC_LEN(TRUNC_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  vit_datapath #(
    .SYM_W     (SYM_W),
    .PM_W      (PM_W),
    .TRUNC_LEN (TRUNC_LEN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .symA    (symA),
    .symB    (symB),
    .ruleSel (ruleSel),
    .outBit  (outBit)
  );
endmodule

// File: tb/sim_vit_re_decoder.sv
module sim_vit_re_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_W  = 3;
  localparam int PM_W   = 7;
  localparam int TL     = 16;
  localparam int MAXLVL = 7;
  localparam int BIG    = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [SYM_W-1:0] symA = '0;
  logic [SYM_W-1:0] symB = '0;
  logic [1:0] ruleSel = 2'b00;
  logic outValid;
  logic outBit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vit_re_decoder #(.SYM_W(SYM_W), .PM_W(PM_W), .TRUNC_LEN(TL)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .symA(symA), .symB(symB),
    .ruleSel(ruleSel), .outValid(outValid), .outBit(outBit)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference: unbounded metrics, histories as bit vectors
  int refPm[4];
  logic [TL-1:0] refSv[4];
  int refSteps = 0;
  int encState = 0;
  bit sentQ[$];
  bit lastExpB = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (step %0d)", tag, act, exp, refSteps);
    end
  endtask

  function automatic int distOf(input int sym, input int bitv);
    return bitv ? (MAXLVL - sym) : sym;
  endfunction

  function automatic int noisy(input int ideal, input int spread);
    int v;
    v = ideal + int'($urandom_range(0, 2 * spread)) - spread;
    if (v < 0) v = 0;
    if (v > MAXLVL) v = MAXLVL;
    return v;
  endfunction

  task automatic refAdvance(input int a, input int b);
    int np[4];
    logic [TL-1:0] ns[4];
    for (int s = 0; s < 4; s++) begin
      int u, pa, pb, ma, mb, w;
      u  = s >> 1;
      pa = (s << 1) & 3;
      pb = pa | 1;
      ma = refPm[pa] + distOf(a, u ^ (pa >> 1) ^ (pa & 1)) + distOf(b, u ^ (pa & 1));
      mb = refPm[pb] + distOf(a, u ^ (pb >> 1) ^ (pb & 1)) + distOf(b, u ^ (pb & 1));
      w  = (mb < ma) ? pb : pa;
      np[s] = (mb < ma) ? mb : ma;
      ns[s] = {refSv[w][TL-2:0], u[0]};
    end
    for (int s = 0; s < 4; s++) begin
      refPm[s] = np[s];
      refSv[s] = ns[s];
    end
  endtask

  function automatic bit refPick(input int rule);
    int bi, cnt;
    if (rule == 1) begin
      bi = 0;
      for (int s = 1; s < 4; s++) if (refPm[s] < refPm[bi]) bi = s;
      return refSv[bi][TL-1];
    end else if (rule == 2) begin
      cnt = 0;
      for (int s = 0; s < 4; s++) cnt += int'(refSv[s][TL-1]);
      return cnt > 2;
    end
    return refSv[0][TL-1];
  endfunction

  function automatic string ruleTag(input int rule);
    if (rule == 1) return "R8 best-state";
    if (rule == 2) return "R9 majority";
    return "R7 fixed-state";
  endfunction

  task automatic applyStep(input bit v, input int a, input int b, input int rule,
                           input bit uSent, input string tag, input bit clean);
    bit expV;
    bit expB;
    @(negedge clk);
    inValid = v;
    symA = SYM_W'(a);
    symB = SYM_W'(b);
    ruleSel = 2'(rule);
    expV = 0;
    expB = lastExpB;
    if (v) begin
      refAdvance(a, b);
      refSteps++;
      sentQ.push_back(uSent);
      expV = (refSteps >= TL);
      expB = refPick(rule);
      lastExpB = expB;
    end
    @(posedge clk);
    #1;
    chk(outValid, expV, (refSteps < TL) ? "R1 no output before fill" : "R2 output strobe");
    if (expV) chk(outBit, expB, $sformatf("%s %s", tag, ruleTag(rule)));
    if (!v && refSteps >= TL) chk(outBit, expB, "R11 idle cycle holds output");
    if (expV && clean) chk(outBit, sentQ[refSteps - TL], "R6 noiseless bit returned");
  endtask

  task automatic encStep(input bit u, input int spread, input int rule,
                         input string tag, input bit clean);
    int c1, c2;
    c1 = int'(u) ^ (encState >> 1) ^ (encState & 1);
    c2 = int'(u) ^ (encState & 1);
    encState = (int'(u) << 1) | (encState >> 1);
    applyStep(1, noisy(c1 * MAXLVL, spread), noisy(c2 * MAXLVL, spread), rule, u, tag, clean);
  endtask

  initial begin
    refPm[0] = 0;
    for (int s = 1; s < 4; s++) refPm[s] = BIG;   // R5 start-up penalty
    for (int s = 0; s < 4; s++) refSv[s] = '0;
    void'($urandom(32'h5eed_0042));

    repeat (3) @(posedge clk);
    #1;
    chk(outValid, 1'b0, "R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid, 1'b0, "R1 after reset");
    chk(outBit, 1'b0, "R1 after reset");

    // noiseless, fixed rule: R4 trellis and R6 exchange
    for (int i = 0; i < 200; i++) encStep(1'($urandom_range(0, 1)), 0, 0, "R4/R5", 1'b1);

    // noiseless with idle gaps carrying junk, best rule
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0)
        applyStep(0, $urandom_range(0, 7), $urandom_range(0, 7), 1, 1'b0, "R11", 1'b0);
      else
        encStep(1'($urandom_range(0, 1)), 0, 1, "R6", 1'b1);
    end

    // moderate noise, best rule
    for (int i = 0; i < 400; i++) encStep(1'($urandom_range(0, 1)), 3, 1, "R3/R4", 1'b0);

    // fully random samples, majority rule (frequent 2-2 splits)
    for (int i = 0; i < 600; i++)
      applyStep(1, $urandom_range(0, 7), $urandom_range(0, 7), 2, 1'b0, "R3", 1'b0);

    // rule changes on every pair, spare code included
    for (int i = 0; i < 400; i++)
      applyStep(1, $urandom_range(0, 7), $urandom_range(0, 7), i % 4, 1'b0, "R7/R8/R9", 1'b0);

    // saturated samples at both extremes
    for (int i = 0; i < 60; i++) applyStep(1, 7, 7, i % 3, 1'b0, "R3 level 7", 1'b0);
    for (int i = 0; i < 60; i++) applyStep(1, 0, 7, i % 3, 1'b0, "R3 mixed levels", 1'b0);

    // long run with idle gaps, metrics wrap many times
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0)
        applyStep(0, $urandom_range(0, 7), $urandom_range(0, 7), i % 3, 1'b0, "R11", 1'b0);
      else
        encStep(1'($urandom_range(0, 1)), 4, $urandom_range(0, 2), "R10 wrap", 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule